// File: doc/BRIEF.md
# Direct-Mapped Line Cache with Write-Through

This block is a direct-mapped data cache for a 32-bit byte address. It keeps 256 lines of sixteen 32-bit words. Each line has one valid bit and an 18-bit tag. A processor issues a read or a write. The lookup is combinational, so a hit returns the addressed word in the same cycle with the stall output low.

When the lookup misses, the cache raises stall and requests the whole line from main memory by its memory line number. Memory returns all sixteen words in a single beat. In that cycle the cache installs the line, its tag and its valid bit. On the next cycle the held access runs again and now hits. Stores complete as hits, whether they hit at once or after a refill. A store writes the addressed word into the line and, one cycle later, issues that same word to memory, so memory always holds what the cache holds.

The processor must hold its request stable for as long as stall is high. Only one refill is ever outstanding.

Top module: `dmc_cache`

## Requirements
- R1: The byte address splits as follows: bits 5:2 pick the word in the line, bits 13:6 pick the line, and bits 31:14 are the tag. Bits 1:0 have no effect on hit or on read data.
- R2: `rsp_hit` is high only when `req_valid` is high, no refill is in progress, the addressed line is valid, and its stored tag equals address bits 31:14.
- R3: On a read hit, `rsp_rdata` carries the addressed word in the same cycle and `rsp_stall` is low.
- R4: On a miss, `rsp_stall` is high in the same cycle. From the next cycle, `mem_fill_req` is high with `mem_fill_line` equal to address bits 31:6. Both stay unchanged until a cycle in which `mem_fill_valid` is high.
- R5: In a cycle where `mem_fill_req` and `mem_fill_valid` are both high, the cache installs all sixteen words of `mem_fill_data`, with word n at bits 32n+31:32n. In the next cycle `mem_fill_req` is low, and the held access hits with stall low.
- R6: While a refill is outstanding, `rsp_stall` stays high and the held request is not taken: no store is performed and `mem_wr_valid` stays low.
- R7: A store hit changes only the addressed word of the line. In the next cycle, `mem_wr_valid` is high for exactly one cycle, with `mem_wr_addr` equal to address bits 31:2 and `mem_wr_data` equal to the store data. A read never raises `mem_wr_valid`.
- R8: A store that misses first refills the line. It then completes as a hit and writes through as in R7.
- R9: Reset clears every valid bit, so the first access to any line after reset misses. After reset, `mem_fill_req` and `mem_wr_valid` are low.
- R10: `rsp_rdata` is zero in every cycle in which `rsp_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor access present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| rsp_rdata | output | 32 | Load data, zero when not hit |
| rsp_hit | output | 1 | Access hits this cycle |
| rsp_stall | output | 1 | Processor must hold the request |
| mem_fill_req | output | 1 | Line refill request |
| mem_fill_line | output | 26 | Memory line number (address bits 31:6) |
| mem_fill_valid | input | 1 | Refill data present |
| mem_fill_data | input | 512 | Whole line, word n at bits 32n+31:32n |
| mem_wr_valid | output | 1 | Write-through beat |
| mem_wr_addr | output | 30 | Word address (address bits 31:2) |
| mem_wr_data | output | 32 | Write-through data |

## Verification
Hit, stall and read data are combinational, so the bench samples them 1 ns after the falling edge on which it drives a request. The refill request is registered, so the bench looks for it one falling edge after the miss. The bench answers the refill after a random wait of zero to three cycles. It expects the replayed hit on the falling edge that follows the edge on which the line arrives. The write-through beat is checked on the falling edge after the store is taken; on that same sample a read must show no beat. Addresses are drawn from a few tags and line indexes so that hits, conflict misses and store-after-refill all occur, next to directed probes of the offset bits and of the words beside a store.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    localparam int DMC_ADDR_W = 32;
    localparam int DMC_WORD_W = 32;
    localparam int DMC_WORDS  = 16;
    localparam int DMC_LINES  = 256;

    typedef enum logic {
        DMC_IDLE = 1'b0,
        DMC_FILL = 1'b1
    } dmc_fsm_e;

endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 2,
    parameter int WSEL_W = 4,
    parameter int IDX_W  = 8,
    localparam int TAG_W   = ADDR_W - OFS_W - WSEL_W - IDX_W,
    localparam int LNUM_W  = TAG_W + IDX_W,
    localparam int WADDR_W = ADDR_W - OFS_W
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [TAG_W-1:0]   tag,
    output logic [IDX_W-1:0]   idx,
    output logic [WSEL_W-1:0]  wsel,
    output logic [LNUM_W-1:0]  lnum,
    output logic [WADDR_W-1:0] waddr
);
    // Byte offset only sizes the access; lookup never sees it.
    logic unused_ofs;
    assign unused_ofs = ^addr[OFS_W-1:0];

    assign wsel  = addr[OFS_W +: WSEL_W];
    assign idx   = addr[OFS_W + WSEL_W +: IDX_W];
    assign tag   = addr[ADDR_W-1 -: TAG_W];
    assign lnum  = addr[ADDR_W-1 -: LNUM_W];
    assign waddr = addr[ADDR_W-1 -: WADDR_W];
endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int LINES = 256,
    parameter int TAG_W = 18,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             match,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [LINES-1:0] valid_d, valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_comb begin
        valid_d = valid_q;
        if (wr_en) valid_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_idx] <= wr_tag;
    end

    assign match = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);

    p_valid_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)]);

    p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_q == '0));
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int LINES  = 256,
    parameter int WORDS  = 16,
    parameter int WORD_W = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS),
    localparam int LINE_W = WORDS * WORD_W
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_wsel,
    output logic [WORD_W-1:0] rd_word,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              st_en,
    input  logic [IDX_W-1:0]  st_idx,
    input  logic [WSEL_W-1:0] st_wsel,
    input  logic [WORD_W-1:0] st_data
);
    logic [WORD_W-1:0] bank_rd [WORDS];

    // One bank per word position: a refill writes every bank, a store one.
    for (genvar w = 0; w < WORDS; w++) begin : g_bank
        logic [WORD_W-1:0] bank_q [LINES];
        logic              st_hit_w;

        assign st_hit_w = st_en && (st_wsel == WSEL_W'(w));

        always_ff @(posedge clk) begin
            if (fill_en)       bank_q[fill_idx] <= fill_line[w*WORD_W +: WORD_W];
            else if (st_hit_w) bank_q[st_idx]   <= st_data;
        end

        assign bank_rd[w] = bank_q[rd_idx];
    end

    assign rd_word = bank_rd[rd_wsel];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl #(
    parameter int LNUM_W  = 26,
    parameter int WADDR_W = 30,
    parameter int WORD_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [LNUM_W-1:0]  req_lnum,
    input  logic [WADDR_W-1:0] req_waddr,
    input  logic [WORD_W-1:0]  req_wdata,
    input  logic               lookup_hit,
    input  logic               mem_fill_valid,
    output logic               rsp_hit,
    output logic               rsp_stall,
    output logic               fill_en,
    output logic               st_en,
    output logic               mem_fill_req,
    output logic [LNUM_W-1:0]  mem_fill_line,
    output logic               mem_wr_valid,
    output logic [WADDR_W-1:0] mem_wr_addr,
    output logic [WORD_W-1:0]  mem_wr_data
);
    import dmc_pkg::*;

    typedef struct packed {
        dmc_fsm_e           fsm;
        logic               fill_req;
        logic [LNUM_W-1:0]  fill_line;
        logic               wr_valid;
        logic [WADDR_W-1:0] wr_addr;
        logic [WORD_W-1:0]  wr_data;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.wr_valid = 1'b0;
        fill_en       = 1'b0;
        st_en         = 1'b0;
        rsp_hit       = req_valid && lookup_hit && (st_q.fsm == DMC_IDLE);
        rsp_stall     = (st_q.fsm == DMC_FILL) || (req_valid && !lookup_hit);

        unique case (st_q.fsm)
            DMC_IDLE: begin
                if (req_valid && !lookup_hit) begin
                    st_d.fsm       = DMC_FILL;
                    st_d.fill_req  = 1'b1;
                    st_d.fill_line = req_lnum;
                end else if (rsp_hit && req_write) begin
                    st_en         = 1'b1;
                    st_d.wr_valid = 1'b1;
                    st_d.wr_addr  = req_waddr;
                    st_d.wr_data  = req_wdata;
                end
            end
            DMC_FILL: begin
                if (mem_fill_valid) begin
                    fill_en       = 1'b1;
                    st_d.fsm      = DMC_IDLE;
                    st_d.fill_req = 1'b0;
                end
            end
            default: st_d.fsm = DMC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.fsm       <= DMC_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_fill_req  = st_q.fill_req;
    assign mem_fill_line = st_q.fill_line;
    assign mem_wr_valid  = st_q.wr_valid;
    assign mem_wr_addr   = st_q.wr_addr;
    assign mem_wr_data   = st_q.wr_data;

    p_fill_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_fill_req && !mem_fill_valid) |=> (mem_fill_req && $stable(mem_fill_line)));

    p_no_wr_in_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_fill_req |-> (!mem_wr_valid && rsp_stall));

    p_wr_after_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> $past(rsp_hit && req_write));

    p_fill_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_fill_req && mem_fill_valid) |=> !mem_fill_req);
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
    parameter int ADDR_W = dmc_pkg::DMC_ADDR_W,
    parameter int WORD_W = dmc_pkg::DMC_WORD_W,
    parameter int WORDS  = dmc_pkg::DMC_WORDS,
    parameter int LINES  = dmc_pkg::DMC_LINES,
    localparam int OFS_W   = $clog2(WORD_W / 8),
    localparam int WSEL_W  = $clog2(WORDS),
    localparam int IDX_W   = $clog2(LINES),
    localparam int TAG_W   = ADDR_W - OFS_W - WSEL_W - IDX_W,
    localparam int LNUM_W  = TAG_W + IDX_W,
    localparam int WADDR_W = ADDR_W - OFS_W,
    localparam int LINE_W  = WORDS * WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [WORD_W-1:0]  req_wdata,
    output logic [WORD_W-1:0]  rsp_rdata,
    output logic               rsp_hit,
    output logic               rsp_stall,
    output logic               mem_fill_req,
    output logic [LNUM_W-1:0]  mem_fill_line,
    input  logic               mem_fill_valid,
    input  logic [LINE_W-1:0]  mem_fill_data,
    output logic               mem_wr_valid,
    output logic [WADDR_W-1:0] mem_wr_addr,
    output logic [WORD_W-1:0]  mem_wr_data
);
    logic [TAG_W-1:0]   a_tag;
    logic [IDX_W-1:0]   a_idx;
    logic [WSEL_W-1:0]  a_wsel;
    logic [LNUM_W-1:0]  a_lnum;
    logic [WADDR_W-1:0] a_waddr;
    logic               lookup_hit;
    logic               fill_en;
    logic               st_en;
    logic [WORD_W-1:0]  rd_word;
    logic [IDX_W-1:0]   fill_idx;
    logic [TAG_W-1:0]   fill_tag;

    dmc_addr_split #(
        .ADDR_W(ADDR_W), .OFS_W(OFS_W), .WSEL_W(WSEL_W), .IDX_W(IDX_W)
    ) u_split (
        .addr(req_addr), .tag(a_tag), .idx(a_idx), .wsel(a_wsel),
        .lnum(a_lnum), .waddr(a_waddr)
    );

    // The refill target comes from the registered line number, not the live address.
    assign fill_idx = mem_fill_line[IDX_W-1:0];
    assign fill_tag = mem_fill_line[LNUM_W-1:IDX_W];

    dmc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(a_idx), .rd_tag(a_tag), .match(lookup_hit),
        .wr_en(fill_en), .wr_idx(fill_idx), .wr_tag(fill_tag)
    );

    dmc_data_store #(.LINES(LINES), .WORDS(WORDS), .WORD_W(WORD_W)) u_data (
        .clk(clk),
        .rd_idx(a_idx), .rd_wsel(a_wsel), .rd_word(rd_word),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_line(mem_fill_data),
        .st_en(st_en), .st_idx(a_idx), .st_wsel(a_wsel), .st_data(req_wdata)
    );

    dmc_ctrl #(.LNUM_W(LNUM_W), .WADDR_W(WADDR_W), .WORD_W(WORD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_lnum(a_lnum), .req_waddr(a_waddr), .req_wdata(req_wdata),
        .lookup_hit(lookup_hit), .mem_fill_valid(mem_fill_valid),
        .rsp_hit(rsp_hit), .rsp_stall(rsp_stall),
        .fill_en(fill_en), .st_en(st_en),
        .mem_fill_req(mem_fill_req), .mem_fill_line(mem_fill_line),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data)
    );

    assign rsp_rdata = rsp_hit ? rd_word : '0;

    p_hit_no_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> !rsp_stall);

    p_rdata_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_rdata == '0));
endmodule

// File: tb/sim_dmc_cache.sv
`timescale 1ns/1ps
module sim_dmc_cache;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic [31:0]  rsp_rdata;
    logic         rsp_hit;
    logic         rsp_stall;
    logic         mem_fill_req;
    logic [25:0]  mem_fill_line;
    logic         mem_fill_valid = 1'b0;
    logic [511:0] mem_fill_data = '0;
    logic         mem_wr_valid;
    logic [29:0]  mem_wr_addr;
    logic [31:0]  mem_wr_data;

    dmc_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_hit(rsp_hit), .rsp_stall(rsp_stall),
        .mem_fill_req(mem_fill_req), .mem_fill_line(mem_fill_line),
        .mem_fill_valid(mem_fill_valid), .mem_fill_data(mem_fill_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data)
    );

    always #10 clk = ~clk;

    int unsigned n_vec  = 0;
    int unsigned n_miss = 0;
    logic [31:0] mem_w [int unsigned];
    bit          m_val [256];
    logic [17:0] m_tag [256];

    function automatic logic [31:0] mem_word(input logic [29:0] wa);
        if (mem_w.exists(int'(wa))) return mem_w[int'(wa)];
        return (32'(wa) * 32'h9E3779B1) ^ 32'h5A5A1234;
    endfunction

    function automatic logic [511:0] line_image(input logic [25:0] ln);
        logic [511:0] v;
        for (int w = 0; w < 16; w++) v[w*32 +: 32] = mem_word({ln, 4'(w)});
        return v;
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Drive one access, service any refill, check every due result.
    task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd);
        logic [7:0]  ix = a[13:6];
        bit          hit_e = m_val[ix] && (m_tag[ix] == a[31:14]);
        int unsigned lat;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        #1;
        chk("R2 hit flag", 32'(rsp_hit), 32'(hit_e));
        if (!hit_e) begin
            chk("R4 stall on miss", 32'(rsp_stall), 1);
            chk("R10 rdata zero on miss", rsp_rdata, 0);
            @(negedge clk); #1;
            chk("R4 fill request", 32'(mem_fill_req), 1);
            chk("R4 fill line number", 32'(mem_fill_line), 32'(a[31:6]));
            lat = $urandom_range(0, 3);
            for (int k = 0; k < int'(lat); k++) begin
                @(negedge clk); #1;
                chk("R4 fill request held", 32'(mem_fill_req), 1);
                chk("R6 stall held during fill", 32'(rsp_stall), 1);
                chk("R6 no write-through during fill", 32'(mem_wr_valid), 0);
            end
            mem_fill_valid = 1'b1;
            mem_fill_data  = line_image(a[31:6]);
            @(negedge clk);
            mem_fill_valid = 1'b0;
            mem_fill_data  = '0;
            #1;
            m_val[ix] = 1'b1; m_tag[ix] = a[31:14];
            chk("R5 fill request dropped", 32'(mem_fill_req), 0);
            chk("R5 replayed access hits", 32'(rsp_hit), 1);
        end
        chk("R3 stall low on hit", 32'(rsp_stall), 0);
        if (!wr) chk("R3 read data", rsp_rdata, mem_word(a[31:2]));
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        if (wr) begin
            chk(hit_e ? "R7 write-through valid" : "R8 write-through after refill",
                32'(mem_wr_valid), 1);
            chk("R7 write-through address", 32'(mem_wr_addr), 32'(a[31:2]));
            chk("R7 write-through data", mem_wr_data, wd);
            mem_w[int'(a[31:2])] = wd;
        end else begin
            chk("R7 no write-through on read", 32'(mem_wr_valid), 0);
        end
    endtask

    // Read of a line known to be present.
    task automatic probe(input logic [31:0] a, input string what);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #1;
        chk(what, 32'(rsp_hit), 1);
        chk(what, rsp_rdata, mem_word(a[31:2]));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd7031));
        for (int i = 0; i < 256; i++) m_val[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R9 no fill request after reset", 32'(mem_fill_req), 0);
        chk("R9 no write-through after reset", 32'(mem_wr_valid), 0);
        chk("R9 idle stall low", 32'(rsp_stall), 0);

        // R9: first touch of a line misses
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0001_2344; #1;
        chk("R9 first access misses", 32'(rsp_hit), 0);
        req_valid = 1'b0;
        access(1'b0, 32'h0001_2344, 0);

        // R1: offset bits ignored, word select picks distinct words
        probe(32'h0001_2347, "R1 offset bits ignored");
        probe(32'h0001_2340, "R1 word select low");
        probe(32'h0001_237C, "R1 word select top");

        // R1/R2: same index, different tag is a conflict miss
        access(1'b0, 32'h0005_2344, 0);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0001_2344; #1;
        chk("R1 R2 evicted tag misses", 32'(rsp_hit), 0);
        req_valid = 1'b0;

        // R7: store hit touches one word only
        access(1'b1, 32'h0005_2354, 32'hCAFE_0001);
        probe(32'h0005_2350, "R7 neighbour below unchanged");
        probe(32'h0005_2358, "R7 neighbour above unchanged");
        probe(32'h0005_2354, "R7 stored word readback");

        // R8: store miss refills, then writes through
        access(1'b1, 32'h00A0_0FC8, 32'h1234_ABCD);
        probe(32'h00A0_0FC8, "R8 stored word after refill");
        probe(32'h00A0_0FC0, "R8 refill line intact");

        // Random mix over few tags and indexes
        for (int n = 0; n < 600; n++) begin
            logic [31:0] a;
            a[31:14] = 18'h3 * 18'($urandom_range(0, 3)) + 18'h11;
            a[13:6]  = 8'($urandom_range(0, 7)) * 8'd37;
            a[5:2]   = 4'($urandom_range(0, 15));
            a[1:0]   = 2'($urandom_range(0, 3));
            access($urandom_range(0, 9) < 3, a, $urandom);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_miss++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end
endmodule